// File: doc/BRIEF.md
# ADC Conversion Start Scheduler

This block decides when a single shared analog-to-digital converter starts and which conversion program it runs. Seven request sources compete for it: four motor-PWM event inputs, a timer event, a software request and a continuous-run enable. Each source owns one program code. The winner among the pending requests is latched, and a one-cycle start strobe reaches the converter after a fixed arming delay. A busy flag covers the conversion itself. A fixed gap separates the end of one conversion from the arming of the next.

A request that arrives during a conversion is handled by source type. A motor-PWM request that outranks the running program aborts it. The partial result is dropped, an abort flag pulses, and that PWM program is armed at once. Any other request, including a PWM request that does not outrank the running one, waits as a sticky pending bit until the running program ends. Completed results go alternately to result slot 0 and slot 1. The converter is a behavioural stub. It reports completion a programmable number of cycles after each strobe.

Top module: `adc_start_sched`

## Requirements
- R1: Program codes are 0..3 for PWM events 0..3, 4 for the timer, 5 for software and 6 for continuous run. When more than one source is pending at a decision, the lowest code wins. The winning code is shown on `prog_sel` while `start_pulse` is high.
- R2: A request sampled at clock edge k with the scheduler idle makes `start_pulse` high for exactly one cycle, after edge k+1+START_DLY.
- R3: `busy` rises in the cycle of the start strobe. It falls at the same edge at which `res_valid` rises.
- R4: `res_valid` pulses for one cycle after edge s+N+1. Here s is the edge that raised the strobe and N is `conv_cycles`, with 0 treated as 1.
- R5: Successive completed results report slot 0, 1, 0, 1, ... on `res_slot` with `res_valid`, counted from reset. Aborted conversions do not advance the slot.
- R6: A pending PWM request whose code is lower than the running program's code, seen while `busy`, aborts the conversion. `abort_pulse` is high for one cycle, no `res_valid` follows for the aborted program, and the PWM program's strobe follows START_DLY cycles after the abort.
- R7: Timer, software and continuous requests never abort. A PWM request whose code is equal to or higher than the running one does not abort either. Such requests run after the current program completes.
- R8: Event requests are sticky until their program is armed. Repeated requests from one source before that run its program only once.
- R9: After `res_valid` at edge D, the next strobe comes no earlier than after edge D+GAP_DLY+1+START_DLY. A request pending at D gets exactly that timing.
- R10: While `cont_en` is high and nothing else is pending, program 6 runs back to back. Clearing `cont_en` leaves nothing pending.
- R11: During reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_trig | input | N_PWM | Motor-PWM event requests, bit i is program i |
| tmr_trig | input | 1 | Timer event request |
| sw_trig | input | 1 | Software request |
| cont_en | input | 1 | Continuous-run enable (level) |
| conv_cycles | input | CW | Conversion time of the converter stub, in cycles |
| prog_sel | output | $clog2(N_PWM+3) | Program armed or running |
| start_pulse | output | 1 | One-cycle converter start strobe |
| busy | output | 1 | Conversion in progress |
| abort_pulse | output | 1 | One-cycle flag for a cancelled conversion |
| res_valid | output | 1 | One-cycle result-available strobe |
| res_slot | output | 1 | Result slot of the completed conversion |

## Verification
The bench targets several corner cases.

- Simultaneous requests from PWM, timer and software. A wrong priority encoder would start the timer or software program first.
- A high-priority PWM event arriving mid-conversion. A design that queued it would deliver a stale result and no abort. A design that aborted for any request would flag an abort when the timer or a lower-ranked PWM event arrives.
- Duplicate requests while busy. These expose a counter that replays a source twice.
- The slot sequence across an abort. This catches a toggle placed at the strobe rather than at completion.
- Continuous mode, where start-to-start spacing must equal conversion plus gap plus arming exactly.

Random traffic is then compared cycle by cycle with a bench model.

// File: rtl/adc_sched_pkg.sv
package adc_sched_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ARM  = 2'd1,
      PH_CONV = 2'd2,
      PH_GAP  = 2'd3
   } sched_phase_t;

   function automatic int unsigned cnt_width(input int unsigned max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction

endpackage

// File: rtl/adc_req_latch.sv
module adc_req_latch #(
   parameter int NSRC       = 7,
   parameter bit LEVEL_LAST = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] req_in,
   input  logic [NSRC-1:0] clr,
   output logic [NSRC-1:0] pend
);

   if (NSRC < 2) begin : g_bad_nsrc
      $error("adc_req_latch: NSRC must be at least 2");
   end

   for (genvar g = 0; g < NSRC; g++) begin : g_bit
      if (LEVEL_LAST && (g == NSRC - 1)) begin : g_level
         assign pend[g] = req_in[g];
      end else begin : g_sticky
         logic held_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              held_q <= 1'b0;
            else if (req_in[g])      held_q <= 1'b1;
            else if (clr[g])         held_q <= 1'b0;
         end
         assign pend[g] = held_q;

         assert_req_captured_R8: assert property (@(posedge clk) disable iff (!rst_n)
            req_in[g] |=> pend[g]);
         assert_req_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (pend[g] && !clr[g]) |=> pend[g]);
      end
   end

endmodule

// File: rtl/adc_prio_pick.sv
module adc_prio_pick #(
   parameter int N = 7,
   parameter int W = 3
) (
   input  logic [N-1:0] req,
   output logic         any,
   output logic [W-1:0] idx,
   output logic [N-1:0] grant
);

   if (N < 1 || (1 << W) < N) begin : g_bad_width
      $error("adc_prio_pick: W too narrow for N");
   end

   always_comb begin
      any   = |req;
      idx   = '0;
      grant = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            idx      = W'(i);
            grant    = '0;
            grant[i] = 1'b1;
         end
      end
   end

endmodule

// File: rtl/adc_conv_model.sv
module adc_conv_model #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          kill,
   input  logic [CW-1:0] conv_cycles,
   output logic          done
);

   if (CW < 1) begin : g_bad_cw
      $error("adc_conv_model: CW must be at least 1");
   end

   logic [CW-1:0] remain_q;
   logic [CW-1:0] load_val;

   assign load_val = (conv_cycles == '0) ? CW'(1) : conv_cycles;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                remain_q <= '0;
      else if (kill)             remain_q <= '0;
      else if (start)            remain_q <= load_val;
      else if (remain_q != '0)   remain_q <= remain_q - CW'(1);
   end

   assign done = (remain_q == CW'(1));

   assert_kill_quiets_R6: assert property (@(posedge clk) disable iff (!rst_n)
      kill |=> !done);
   assert_short_conv_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !kill && conv_cycles <= CW'(1)) |=> done);

endmodule

// File: rtl/adc_start_sched.sv
module adc_start_sched
   import adc_sched_pkg::*;
#(
   parameter int N_PWM     = 4,
   parameter int START_DLY = 3,
   parameter int GAP_DLY   = 2,
   parameter int CW        = 8,
   localparam int NSRC     = N_PWM + 3,
   localparam int SW       = $clog2(NSRC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_PWM-1:0] pwm_trig,
   input  logic             tmr_trig,
   input  logic             sw_trig,
   input  logic             cont_en,
   input  logic [CW-1:0]    conv_cycles,
   output logic [SW-1:0]    prog_sel,
   output logic             start_pulse,
   output logic             busy,
   output logic             abort_pulse,
   output logic             res_valid,
   output logic             res_slot
);

   localparam int DMAX = (START_DLY > GAP_DLY) ? START_DLY : GAP_DLY;
   localparam int DCW  = cnt_width(DMAX);

   if (N_PWM < 1) begin : g_bad_pwm
      $error("adc_start_sched: N_PWM must be at least 1");
   end
   if (START_DLY < 1) begin : g_bad_start
      $error("adc_start_sched: START_DLY must be at least 1");
   end
   if (GAP_DLY < 0) begin : g_bad_gap
      $error("adc_start_sched: GAP_DLY must not be negative");
   end

   // request capture
   logic [NSRC-1:0] req_vec, pend, clr;
   assign req_vec = {cont_en, sw_trig, tmr_trig, pwm_trig};

   adc_req_latch #(.NSRC(NSRC), .LEVEL_LAST(1'b1)) u_latch (
      .clk    (clk),
      .rst_n  (rst_n),
      .req_in (req_vec),
      .clr    (clr),
      .pend   (pend)
   );

   // overall winner
   logic            pick_any;
   logic [SW-1:0]   pick_idx;
   logic [NSRC-1:0] pick_grant;

   adc_prio_pick #(.N(NSRC), .W(SW)) u_pick (
      .req   (pend),
      .any   (pick_any),
      .idx   (pick_idx),
      .grant (pick_grant)
   );

   // PWM requests that outrank the running program
   sched_phase_t     phase_q, phase_d;
   logic [SW-1:0]    prog_q, prog_d;
   logic [N_PWM-1:0] hp_req, hp_grant;
   logic             hp_any;
   logic [SW-1:0]    hp_idx;

   for (genvar g = 0; g < N_PWM; g++) begin : g_hp
      assign hp_req[g] = pend[g] && (SW'(g) < prog_q);
   end

   adc_prio_pick #(.N(N_PWM), .W(SW)) u_hp_pick (
      .req   (hp_req),
      .any   (hp_any),
      .idx   (hp_idx),
      .grant (hp_grant)
   );

   // converter stub
   logic conv_done, kill;

   adc_conv_model #(.CW(CW)) u_conv (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start_pulse),
      .kill        (kill),
      .conv_cycles (conv_cycles),
      .done        (conv_done)
   );

   // sequencer
   logic [DCW-1:0] tmr_q, tmr_d;
   logic           slot_q, slot_d;
   logic           start_d, abort_d, rv_d, rslot_d;

   always_comb begin
      phase_d = phase_q;
      prog_d  = prog_q;
      tmr_d   = tmr_q;
      slot_d  = slot_q;
      rslot_d = res_slot;
      start_d = 1'b0;
      abort_d = 1'b0;
      rv_d    = 1'b0;
      clr     = '0;
      kill    = 1'b0;
      unique case (phase_q)
         PH_IDLE: begin
            if (pick_any) begin
               clr     = pick_grant;
               prog_d  = pick_idx;
               tmr_d   = DCW'(START_DLY);
               phase_d = PH_ARM;
            end
         end
         PH_ARM: begin
            if (tmr_q == DCW'(1)) begin
               start_d = 1'b1;
               phase_d = PH_CONV;
            end else begin
               tmr_d = tmr_q - DCW'(1);
            end
         end
         PH_CONV: begin
            if (conv_done) begin
               rv_d    = 1'b1;
               rslot_d = slot_q;
               slot_d  = ~slot_q;
               if (GAP_DLY == 0) begin
                  phase_d = PH_IDLE;
               end else begin
                  tmr_d   = DCW'(GAP_DLY);
                  phase_d = PH_GAP;
               end
            end else if (hp_any) begin
               kill                = 1'b1;
               abort_d             = 1'b1;
               clr[N_PWM-1:0]      = hp_grant;
               prog_d              = hp_idx;
               tmr_d               = DCW'(START_DLY);
               phase_d             = PH_ARM;
            end
         end
         PH_GAP: begin
            if (tmr_q <= DCW'(1)) phase_d = PH_IDLE;
            else                  tmr_d   = tmr_q - DCW'(1);
         end
         default: phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q     <= PH_IDLE;
         prog_q      <= '0;
         tmr_q       <= '0;
         slot_q      <= 1'b0;
         start_pulse <= 1'b0;
         abort_pulse <= 1'b0;
         res_valid   <= 1'b0;
         res_slot    <= 1'b0;
      end else begin
         phase_q     <= phase_d;
         prog_q      <= prog_d;
         tmr_q       <= tmr_d;
         slot_q      <= slot_d;
         start_pulse <= start_d;
         abort_pulse <= abort_d;
         res_valid   <= rv_d;
         res_slot    <= rslot_d;
      end
   end

   assign busy     = (phase_q == PH_CONV);
   assign prog_sel = prog_q;

   assert_grant_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(pick_grant));
   assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |=> !start_pulse);
   assert_start_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |-> busy);
   assert_result_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> !busy);
   assert_abort_from_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      abort_pulse |-> ($past(busy) && !res_valid && !busy));
   assert_abort_pwm_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
      abort_pulse |-> (prog_sel < SW'(N_PWM)));
   assert_gap_after_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !start_pulse);

endmodule

// File: tb/tb_adc_start_sched.sv
module tb_adc_start_sched;

   localparam int NP = 4;
   localparam int S_D = 3;
   localparam int G_D = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] pwm = '0;
   logic       tmr = 1'b0, sw = 1'b0, cont = 1'b0;
   logic [7:0] conv = 8'd5;
   logic [2:0] prog_sel;
   logic       start_pulse, busy, abort_pulse, res_valid, res_slot;

   int n_chk = 0, n_fail = 0;
   int start_total = 0, rv_total = 0;
   logic mon_slot = 1'b0;

   always #5 clk = ~clk;

   adc_start_sched #(.N_PWM(NP), .START_DLY(S_D), .GAP_DLY(G_D), .CW(8)) dut (
      .clk(clk), .rst_n(rst_n), .pwm_trig(pwm), .tmr_trig(tmr), .sw_trig(sw),
      .cont_en(cont), .conv_cycles(conv), .prog_sel(prog_sel),
      .start_pulse(start_pulse), .busy(busy), .abort_pulse(abort_pulse),
      .res_valid(res_valid), .res_slot(res_slot));

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   endtask

   function automatic int first_req(input logic [6:0] r);
      for (int i = 0; i < 7; i++) if (r[i]) return i;
      return -1;
   endfunction

   // bench reference model
   int m_ph = 0, m_t = 0, m_prog = 0, m_cnt = 0;
   logic m_start = 0, m_abort = 0, m_rv = 0;
   logic [5:0] m_pend = '0;

   always @(posedge clk or negedge rst_n) begin : model
      int w;
      logic kill, o_s, o_a, o_r;
      logic [5:0] clr;
      if (!rst_n) begin
         m_ph = 0; m_t = 0; m_prog = 0; m_cnt = 0;
         m_start = 0; m_abort = 0; m_rv = 0; m_pend = '0;
      end else begin
         o_s = 0; o_a = 0; o_r = 0; kill = 0; clr = '0;
         case (m_ph)
            0: begin
               w = first_req({cont, m_pend});
               if (w >= 0) begin
                  if (w < 6) clr[w] = 1'b1;
                  m_prog = w; m_ph = 1; m_t = S_D;
               end
            end
            1: if (m_t == 1) begin o_s = 1; m_ph = 2; end else m_t--;
            2: if (m_cnt == 1) begin
                  o_r = 1;
                  if (G_D == 0) m_ph = 0; else begin m_ph = 3; m_t = G_D; end
               end else begin
                  w = -1;
                  for (int i = NP - 1; i >= 0; i--) if (m_pend[i] && i < m_prog) w = i;
                  if (w >= 0) begin
                     o_a = 1; kill = 1; clr[w] = 1'b1; m_prog = w; m_ph = 1; m_t = S_D;
                  end
               end
            default: if (m_t <= 1) m_ph = 0; else m_t--;
         endcase
         if (kill) m_cnt = 0;
         else if (m_start) m_cnt = (conv == 0) ? 1 : int'(conv);
         else if (m_cnt != 0) m_cnt--;
         m_pend = (m_pend & ~clr) | {sw, tmr, pwm};
         m_start = o_s; m_abort = o_a; m_rv = o_r;
      end
   end

   // per-cycle comparison and monitors
   always @(negedge clk) begin
      if (rst_n) begin
         check("R2 start strobe", start_pulse, m_start);
         check("R3 busy", busy, (m_ph == 2));
         check("R6 abort", abort_pulse, m_abort);
         check("R4 result valid", res_valid, m_rv);
         if (start_pulse) begin
            check("R1 program code", prog_sel, m_prog);
            start_total++;
         end
         if (res_valid) begin
            check("R5 result slot", res_slot, mon_slot);
            mon_slot = ~mon_slot;
            rv_total++;
         end
      end else begin
         mon_slot = 1'b0;
      end
   end

   task automatic pulse(input logic [3:0] p, input logic t, input logic s);
      @(negedge clk); pwm = p; tmr = t; sw = s;
      @(negedge clk); pwm = '0; tmr = 1'b0; sw = 1'b0;
   endtask

   task automatic wait_start(input int lim, output int n, output int p);
      n = 0; p = -1;
      while (n < lim) begin
         @(negedge clk); n++;
         if (start_pulse) begin p = prog_sel; break; end
      end
   endtask

   task automatic wait_rv(input int lim, output int n, output int bc, output int ab);
      n = 0; ab = 0; bc = busy ? 1 : 0;
      while (n < lim) begin
         @(negedge clk); n++;
         if (abort_pulse) ab++;
         if (res_valid) break;
         if (busy) bc++;
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      report();
   end

   initial begin : stim
      int n, p, bc, ab, s0, r0;
      void'($urandom(32'd20240611));
      // R11: reset state
      repeat (2) @(negedge clk);
      check("R11 start", start_pulse, 0);
      check("R11 busy", busy, 0);
      check("R11 abort", abort_pulse, 0);
      check("R11 valid", res_valid, 0);
      check("R11 prog", prog_sel, 0);
      check("R11 slot", res_slot, 0);
      @(negedge clk); rst_n = 1'b1;

      // R2 R3 R4: single software request
      conv = 8'd5;
      pulse(4'h0, 1'b0, 1'b1);
      wait_start(50, n, p);
      check("R2 trigger to strobe", n, S_D + 1);
      check("R1 software code", p, 5);
      wait_rv(50, n, bc, ab);
      check("R4 strobe to result", n, 5 + 1);
      check("R3 busy length", bc, 5 + 1);

      // R1 R9: simultaneous requests
      pulse(4'b0100, 1'b1, 1'b1);
      wait_start(50, n, p);
      check("R1 first pick pwm2", p, 2);
      wait_rv(50, n, bc, ab);
      wait_start(50, n, p);
      check("R9 gap timing", n, G_D + 1 + S_D);
      check("R1 second pick timer", p, 4);
      wait_rv(50, n, bc, ab);
      wait_start(50, n, p);
      check("R1 third pick software", p, 5);
      wait_rv(50, n, bc, ab);

      // R6: PWM aborts a software conversion
      conv = 8'd20;
      pulse(4'h0, 1'b0, 1'b1);
      wait_start(50, n, p);
      r0 = rv_total;
      repeat (2) @(negedge clk);
      pulse(4'b0010, 1'b0, 1'b0);
      n = 0;
      while (n < 20 && !abort_pulse) begin @(negedge clk); n++; end
      check("R6 abort latency", n, 1);
      check("R6 no result for aborted", rv_total - r0, 0);
      wait_start(50, n, p);
      check("R6 restart delay", n, S_D);
      check("R6 restarted program", p, 1);
      wait_rv(50, n, bc, ab);

      // R7: lower PWM and timer do not abort PWM0
      conv = 8'd5;
      pulse(4'b0001, 1'b0, 1'b0);
      wait_start(50, n, p);
      check("R1 pwm0 code", p, 0);
      pulse(4'b1000, 1'b1, 1'b0);
      wait_rv(50, n, bc, ab);
      check("R7 no abort", ab, 0);
      wait_start(50, n, p);
      check("R7 pwm3 after completion", p, 3);
      wait_rv(50, n, bc, ab);
      wait_start(50, n, p);
      check("R7 timer after pwm3", p, 4);
      wait_rv(50, n, bc, ab);

      // R8: repeated requests merge
      pulse(4'h0, 1'b1, 1'b0);
      wait_start(50, n, p);
      pulse(4'h0, 1'b0, 1'b1);
      pulse(4'h0, 1'b0, 1'b1);
      wait_rv(50, n, bc, ab);
      wait_start(50, n, p);
      check("R8 merged software", p, 5);
      wait_rv(50, n, bc, ab);
      s0 = start_total;
      repeat (30) @(negedge clk);
      check("R8 single run", start_total - s0, 0);

      // R10: continuous mode
      conv = 8'd2;
      @(negedge clk); cont = 1'b1;
      wait_start(50, n, p);
      check("R10 continuous code", p, 6);
      for (int k = 0; k < 3; k++) begin
         wait_start(50, n, p);
         check("R10 back-to-back spacing", n, 2 + 1 + G_D + 1 + S_D);
         check("R10 continuous code", p, 6);
      end
      cont = 1'b0;
      wait_rv(50, n, bc, ab);
      s0 = start_total;
      repeat (30) @(negedge clk);
      check("R10 stops when disabled", start_total - s0, 0);

      // random traffic against the model
      for (int c = 0; c < 4000; c++) begin
         @(negedge clk);
         for (int b = 0; b < 4; b++) pwm[b] = ($urandom % 40) == 0;
         tmr = ($urandom % 30) == 0;
         sw  = ($urandom % 30) == 0;
         if (($urandom % 200) == 0) cont = ~cont;
         if (($urandom % 50) == 0) conv = 8'($urandom % 13);
      end
      @(negedge clk); pwm = '0; tmr = 0; sw = 0; cont = 0;
      repeat (80) @(negedge clk);
      report();
   end

endmodule